// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives a serial bit clock from the module clock it runs on. It also produces single-cycle strobes that mark each rising and falling transition of that clock, so a shift engine in the same clock domain can launch and capture data without sampling the divided clock itself. The divide ratio comes from one 32-bit control word, and a law-select bit in that word picks how the ratio is set. In linear law, an 8-bit count gives an even divide of twice the count plus one. In power-of-two law, a 4-bit exponent gives a divide of two raised to that exponent.

A `run` input gates the divider. While `run` is low, the half-period counter is held at zero, the clock output stays at a fixed idle level, and no strobes are produced. When `run` rises, the first transition comes one full half-period later. A control word written while the clock is running is held in a pending copy. It is applied only where one half-period ends and the next begins, so a ratio change never produces a shortened pulse. Choosing a ratio from a target frequency is left to software.

Top module: `sclk_divider`

## Requirements
- R1: With bit 12 of the control word at 1 (linear law), every half-period of `sclk` lasts N+1 input cycles, where N is bits 7:0. N=0 therefore toggles `sclk` on every cycle, which is half the input frequency.
- R2: With bit 12 at 0 (power-of-two law), every half-period lasts 2^(M-1) input cycles, where M is bits 11:8. M=0 is treated as a divide by two, with a half-period of 1 cycle.
- R3: Bits 31:13 of the control word have no effect on the divide ratio.
- R4: `rise_pulse` is high for exactly the one cycle in which `sclk` first shows 1 after a transition, and `fall_pulse` is high for the one cycle in which it first shows 0. The two strobes are never high together.
- R5: When `run` is sampled low, the next cycle shows `sclk` at the idle level (0 by default) with both strobes low, and no strobe marks the return to idle. After `run` is sampled high again, the first transition comes after a full half-period.
- R6: A write while running takes effect at the next half-period boundary. A write sampled on the same clock edge as a boundary takes effect at the boundary after that. A write while idle applies to the next run.
- R7: After reset, `sclk` is at the idle level, both strobes are low, and the control word reads as power-of-two law with M=0 (a half-period of 1 cycle).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables the divider; low forces the idle state |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word: bits 7:0 linear count, bits 11:8 exponent, bit 12 law select |
| sclk | output | 1 | Divided serial clock, 50% duty cycle |
| rise_pulse | output | 1 | One-cycle strobe on a low-to-high transition of `sclk` |
| fall_pulse | output | 1 | One-cycle strobe on a high-to-low transition of `sclk` |

## Verification
A control-word write and a half-period boundary can land on the same clock edge. The pending copy then changes at the same moment the active ratio is reloaded from it. The bench provokes this by running at a 2-cycle half-period and raising the write strobe so that it is sampled exactly on a toggle edge. It checks that the measured half-periods are 2, 2, 2 and only then take the new length. A second run places the write one cycle after a boundary, and the new ratio must then follow at the very next boundary.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

    // Control word field layout
    localparam int LIN_W    = 8;
    localparam int POW_W    = 4;
    localparam int LIN_LSB  = 0;
    localparam int POW_LSB  = 8;
    localparam int LAW_BIT  = 12;
    localparam int WORD_W   = 32;

    // Largest exponent gives a half-period of 2^(POW_MAX-1)
    localparam int POW_MAX  = (1 << POW_W) - 1;
    localparam int CNT_W    = (LIN_W > POW_MAX - 1) ? LIN_W : POW_MAX - 1;

    typedef enum logic {
        LAW_POW2   = 1'b0,
        LAW_LINEAR = 1'b1
    } law_e;

    typedef struct packed {
        law_e             law;
        logic [POW_W-1:0] pexp;
        logic [LIN_W-1:0] lin;
    } divcfg_t;

    typedef logic [CNT_W-1:0] hcount_t;
    typedef logic [CNT_W:0]   hwide_t;

    localparam divcfg_t CFG_RESET = '{law: LAW_POW2, pexp: '0, lin: '0};

    function automatic divcfg_t unpack_cfg(input logic [WORD_W-1:0] w);
        divcfg_t c;
        c.law  = law_e'(w[LAW_BIT]);
        c.pexp = w[POW_LSB +: POW_W];
        c.lin  = w[LIN_LSB +: LIN_W];
        return c;
    endfunction

    // Half-period length minus one, in input cycles
    function automatic hcount_t half_minus1(input divcfg_t c);
        hwide_t span;
        if (c.law == LAW_LINEAR) begin
            return hcount_t'(c.lin);
        end
        if (c.pexp == '0) begin
            return '0;
        end
        span = hwide_t'(1) << (c.pexp - 1'b1);
        return hcount_t'(span - hwide_t'(1));
    endfunction

endpackage

// File: rtl/sclkdiv_cfg.sv
module sclkdiv_cfg
    import sclkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              idle,
    input  logic              boundary,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output hcount_t           act_hm1
);

    divcfg_t pend_q;
    divcfg_t wr_cfg;
    divcfg_t next_pend;

    always_comb begin
        wr_cfg    = unpack_cfg(wdata);
        next_pend = wr ? wr_cfg : pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= CFG_RESET;
        end else begin
            pend_q <= next_pend;
        end
    end

    // Active limit: follows writes freely while idle, else only at boundaries
    always_ff @(posedge clk) begin
        if (rst) begin
            act_hm1 <= half_minus1(CFG_RESET);
        end else if (idle) begin
            act_hm1 <= half_minus1(next_pend);
        end else if (boundary) begin
            act_hm1 <= half_minus1(pend_q);
        end
    end

endmodule

// File: rtl/sclkdiv_count.sv
module sclkdiv_count
    import sclkdiv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  hcount_t limit,
    output logic    boundary
);

    hcount_t cnt_q;

    assign boundary = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || boundary) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + hcount_t'(1);
        end
    end

endmodule

// File: rtl/sclkdiv_edge.sv
module sclkdiv_edge #(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic boundary,
    output logic sclk,
    output logic rise_pulse,
    output logic fall_pulse
);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sclk       <= IDLE_LEVEL;
            rise_pulse <= 1'b0;
            fall_pulse <= 1'b0;
        end else if (boundary) begin
            sclk       <= !sclk;
            rise_pulse <= !sclk;
            fall_pulse <= sclk;
        end else begin
            rise_pulse <= 1'b0;
            fall_pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
    import sclkdiv_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic        sclk,
    output logic        rise_pulse,
    output logic        fall_pulse
);

    hcount_t act_hm1;
    logic    boundary;

    sclkdiv_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .idle     (!run),
        .boundary (boundary),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .act_hm1  (act_hm1)
    );

    sclkdiv_count u_count (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .limit    (act_hm1),
        .boundary (boundary)
    );

    sclkdiv_edge #(
        .IDLE_LEVEL (IDLE_LEVEL)
    ) u_edge (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .boundary   (boundary),
        .sclk       (sclk),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse)
    );

endmodule

// File: rtl/sclkdiv_chk.sv
module sclkdiv_chk
    import sclkdiv_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input logic    clk,
    input logic    rst,
    input logic    run,
    input logic    sclk,
    input logic    rise_pulse,
    input logic    fall_pulse,
    input hcount_t act_hm1
);

    assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
        !run |=> (sclk == IDLE_LEVEL));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !run |=> !(rise_pulse || fall_pulse));

    assert_rise_marks_edge_R4: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |-> (sclk && !$past(sclk)));

    assert_fall_marks_edge_R4: assert property (@(posedge clk) disable iff (rst)
        fall_pulse |-> (!sclk && $past(sclk)));

    assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rise_pulse, fall_pulse}));

    // Half-period of one cycle: every running edge must flip the clock (R1, R2)
    assert_fastest_toggle_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(run) && ($past(act_hm1) == '0)) |-> (sclk != $past(sclk)));

endmodule

bind sclk_divider sclkdiv_chk #(
    .IDLE_LEVEL (IDLE_LEVEL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .sclk       (sclk),
    .rise_pulse (rise_pulse),
    .fall_pulse (fall_pulse),
    .act_hm1    (act_hm1)
);

// File: tb/sclk_divider_test.sv
module sclk_divider_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        sclk;
    logic        rise_pulse;
    logic        fall_pulse;

    int   n_checks = 0;
    int   n_fail = 0;
    int   iv[$];
    int   cnt;
    int   pulse_err;
    logic prev;
    logic run_d;

    always #4 clk = ~clk;

    sclk_divider uut (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .sclk       (sclk),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse)
    );

    function automatic int exp_half(input logic [31:0] w);
        int m;
        if (w[12]) return int'(w[7:0]) + 1;
        m = int'(w[11:8]);
        if (m == 0) return 1;
        return 1 << (m - 1);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // One clock: sample at the falling edge, record transitions and strobe errors
    task automatic step();
        run_d = run;
        @(negedge clk);
        if (run_d) cnt++;
        if (run_d) begin
            if (rise_pulse !== (sclk && !prev)) pulse_err++;
            if (fall_pulse !== (!sclk && prev)) pulse_err++;
            if (sclk !== prev) begin
                iv.push_back(cnt);
                cnt = 0;
            end
        end else if (rise_pulse || fall_pulse) begin
            pulse_err++;
        end
        prev = sclk;
    endtask

    task automatic write_idle(input logic [31:0] w);
        cfg_wdata = w;
        cfg_wr = 1'b1;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic start_run();
        iv.delete();
        cnt = 0;
        pulse_err = 0;
        prev = sclk;
        run = 1'b1;
    endtask

    task automatic wait_halves(input int n);
        int guard = 0;
        while (iv.size() < n && guard < 40000) begin
            step();
            guard++;
        end
    endtask

    task automatic check_halves(input int exp[$], input string req, input string what);
        int bad = -1;
        for (int i = 0; i < exp.size(); i++) begin
            if (i >= iv.size()) begin
                if (bad < 0) bad = i;
            end else if (iv[i] != exp[i] && bad < 0) begin
                bad = i;
            end
        end
        if (bad < 0) begin
            check(1'b1, req, what, 0, 0);
        end else begin
            check(1'b0, req, $sformatf("%s half #%0d", what, bad),
                  (bad < iv.size()) ? iv[bad] : -1, exp[bad]);
        end
    endtask

    task automatic stop_check(input string what);
        run = 1'b0;
        step();
        check(sclk === 1'b0, "R5", {what, " idle level"}, sclk, 0);
        check(pulse_err == 0, "R4", {what, " strobe errors"}, pulse_err, 0);
    endtask

    task automatic run_case(input logic [31:0] w, input int n, input string req,
                            input string what);
        int exp[$];
        int h = exp_half(w);
        write_idle(w);
        start_run();
        wait_halves(n);
        for (int i = 0; i < n; i++) exp.push_back(h);
        check_halves(exp, req, what);
        stop_check(what);
    endtask

    initial begin
        #(8 * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R7: reset state
        check(sclk === 1'b0 && rise_pulse === 1'b0 && fall_pulse === 1'b0, "R7",
              "reset outputs", {sclk, rise_pulse, fall_pulse}, 0);
        rst = 1'b0;
        step();
        // R7: default control word gives 1-cycle halves
        begin
            int e1[$] = '{1, 1, 1, 1};
            start_run();
            wait_halves(4);
            check_halves(e1, "R7", "default ratio");
            stop_check("default");
        end

        run_case(32'h0000_1000, 6, "R1", "linear N=0");
        run_case(32'h0000_10FF, 2, "R1", "linear N=255");
        run_case(32'h0000_1009, 4, "R1", "linear N=9");
        run_case(32'hFFFF_E000, 4, "R3", "pow M=0 with upper bits set");
        run_case(32'h0000_0100, 4, "R2", "pow M=1");
        run_case(32'h0000_0500, 3, "R2", "pow M=5");
        run_case(32'h0000_0F00, 2, "R2", "pow M=15");
        run_case(32'hABCD_E0FF, 3, "R3", "pow M=0 junk in high and linear bits");

        for (int k = 0; k < 20; k++) begin
            logic [31:0] w;
            w = $urandom() & 32'hFFFF_E000;
            w[12] = $urandom_range(1, 0);
            w[11:8] = 4'($urandom_range(7, 0));
            w[7:0] = 8'($urandom_range(47, 0));
            run_case(w, 4, w[12] ? "R1" : "R2", $sformatf("random word %h", w));
        end

        // R6: write one cycle after a boundary, applied at the next boundary
        begin
            int e2[$] = '{3, 3, 5, 5};
            write_idle(32'h0000_1002);
            start_run();
            wait_halves(1);
            cfg_wdata = 32'h0000_1004;
            cfg_wr = 1'b1;
            step();
            cfg_wr = 1'b0;
            wait_halves(4);
            check_halves(e2, "R6", "write mid half");
            stop_check("R6 mid");
        end

        // R6: write sampled on a boundary edge, applied one boundary later
        begin
            int e3[$] = '{2, 2, 2, 4, 4};
            write_idle(32'h0000_1001);
            start_run();
            wait_halves(1);
            step();
            cfg_wdata = 32'h0000_1003;
            cfg_wr = 1'b1;
            step();
            cfg_wr = 1'b0;
            wait_halves(5);
            check_halves(e3, "R6", "write on boundary");
            stop_check("R6 coincident");
        end

        // R5: drop run mid half, then restart with a full first half
        begin
            int e4[$] = '{5, 5};
            write_idle(32'h0000_1004);
            start_run();
            wait_halves(1);
            step();
            step();
            run = 1'b0;
            step();
            check(sclk === 1'b0 && !rise_pulse && !fall_pulse, "R5",
                  "idle after mid-half drop", {sclk, rise_pulse, fall_pulse}, 0);
            start_run();
            wait_halves(2);
            check_halves(e4, "R5", "restart half length");
            stop_check("R5 restart");
        end

        summary();
        $finish;
    end

endmodule